// File: doc/BRIEF.md
# Supply Fault Latch and On/Off Controller

This is the digital control core of a power-supply supervisor. It receives comparator flags that are already digital: over-voltage on three rails, under-voltage on two rails, and an on/off request from the host that is active low. Each flag passes through its own persistence filter. A qualified fault sets a sticky latch. The block drives an active-high `rails_off` output that shuts down the main converter, and a `pg_ok` permission signal that goes to the power-good logic.

All timing is counted in pulses of a one-microsecond strobe, `tick_us`. The on/off request must hold a new level for a debounce window before it is accepted. Once accepted, switching on takes effect at once. Switching off waits an extra hold-off interval. Under-voltage checking stays blanked for a while after each switch-on, so the rails can ramp up, even into a shorted load. The fault latch clears only when the accepted request moves from on to off, or on reset.

Top module: `supply_guard`

## Requirements
- R1: Out of reset, `rails_off`=1, `fault_latched`=0 and `pg_ok`=1. `rails_off` is 0 only while the accepted request is on (`on_req_n` low) and no fault is latched.
- R2: A new level of `on_req_n`, in either direction, is accepted only after it has held for DEB_TICKS strobes in a row. A shorter excursion has no effect on `rails_off`.
- R3: Accepting an on request clears `rails_off` on the next clock. Accepting an off request sets `rails_off` only after a further OFF_TICKS strobes.
- R4: An over-voltage flag on any of the three rails (`ov_flag` bits 0 to 2) becomes a fault after OV_TICKS strobes of continuous assertion. A shorter pulse is ignored.
- R5: An under-voltage flag on either rail (`uv_flag` bits 0 and 1) becomes a fault after UV_TICKS strobes of continuous assertion. It is counted only once BLANK_TICKS strobes have passed since the request was accepted as on. Flags during the blanking window are ignored.
- R6: While a fault is latched, `rails_off`=1 and `pg_ok`=0.
- R7: A latched fault stays set after the flags clear. It clears only on the accepted on-to-off transition of the request, or on reset.
- R8: Qualified faults are not latched while the accepted request is off.
- R9: Every filter, debounce and delay counter advances only on a cycle with `tick_us` high.
- R10: Each asynchronous input passes through a two-flop synchroniser before any filter sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (supply removal) |
| tick_us | input | 1 | One-cycle strobe each microsecond |
| ov_flag | input | 3 | Over-voltage comparator flags, one per rail |
| uv_flag | input | 2 | Under-voltage comparator flags, one per rail |
| on_req_n | input | 1 | Remote on/off request, low = on |
| rails_off | output | 1 | Fault-protect output, high = main rails off |
| pg_ok | output | 1 | Permission for power-good, low while a fault is latched |
| fault_latched | output | 1 | Fault latch state |

## Verification
The bound checker enforces these on every cycle: the latch holds between clearing edges, a latched fault forces the rails off, the rails stay off after an accepted switch-on only when a fault is latched, no under-voltage qualification happens inside the blanking window, and an over-voltage qualification is preceded by a synchronised flag. The exact lengths of the debounce, hold-off, blanking and persistence windows, the rejection of short pulses, and the behaviour with a sparse strobe can only be shown by the bench scenarios. The bench compares every output against its cycle model on each clock.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    // Accepted request levels (matches the active-low pin sense)
    localparam logic REQ_ON  = 1'b0;
    localparam logic REQ_OFF = 1'b1;

    typedef struct packed {
        logic fault;
    } latch_state_t;

endpackage

// File: rtl/sg_sync_bank.sv
module sg_sync_bank #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/sg_qual_filter.sv
module sg_qual_filter #(
    parameter int LEN = 73
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic flag,
    output logic hit
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hit;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!flag) begin
            st_d.cnt = '0;
            st_d.hit = 1'b0;
        end else if (tick && !st_q.hit) begin
            if (st_q.cnt == CW'(LEN - 1)) begin
                st_d.hit = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hit = st_q.hit;
endmodule

// File: rtl/sg_onoff_ctrl.sv
module sg_onoff_ctrl
    import supply_guard_pkg::*;
#(
    parameter int DEB_TICKS   = 38000,
    parameter int OFF_TICKS   = 2300,
    parameter int BLANK_TICKS = 75000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req_sync,
    output logic deb_req,
    output logic deb_rise,
    output logic off_cmd,
    output logic uv_en
);
    localparam int DW = $clog2(DEB_TICKS + 1);
    localparam int OW = $clog2(OFF_TICKS + 1);
    localparam int BW = $clog2(BLANK_TICKS + 1);

    typedef struct packed {
        logic          deb;
        logic          deb_prev;
        logic          off;
        logic          uv_en;
        logic [DW-1:0] dcnt;
        logic [OW-1:0] ocnt;
        logic [BW-1:0] bcnt;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.deb_prev = st_q.deb;

        // request debounce, symmetric in both directions
        if (req_sync == st_q.deb) begin
            st_d.dcnt = '0;
        end else if (tick) begin
            if (st_q.dcnt == DW'(DEB_TICKS - 1)) begin
                st_d.deb  = req_sync;
                st_d.dcnt = '0;
            end else begin
                st_d.dcnt = st_q.dcnt + 1'b1;
            end
        end

        // switch-off hold-off; switch-on is immediate
        if (st_q.deb == REQ_ON) begin
            st_d.off  = 1'b0;
            st_d.ocnt = '0;
        end else if (st_q.off) begin
            st_d.ocnt = '0;
        end else if (tick) begin
            if (st_q.ocnt == OW'(OFF_TICKS - 1)) begin
                st_d.off  = 1'b1;
                st_d.ocnt = '0;
            end else begin
                st_d.ocnt = st_q.ocnt + 1'b1;
            end
        end

        // under-voltage blanking after switch-on
        if (st_q.deb == REQ_OFF) begin
            st_d.uv_en = 1'b0;
            st_d.bcnt  = '0;
        end else if (!st_q.uv_en && tick) begin
            if (st_q.bcnt == BW'(BLANK_TICKS - 1)) begin
                st_d.uv_en = 1'b1;
                st_d.bcnt  = '0;
            end else begin
                st_d.bcnt = st_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            st_q.deb      <= REQ_OFF;
            st_q.deb_prev <= REQ_OFF;
            st_q.off      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign deb_req  = st_q.deb;
    assign deb_rise = (st_q.deb == REQ_OFF) && (st_q.deb_prev == REQ_ON);
    assign off_cmd  = st_q.off;
    assign uv_en    = st_q.uv_en;
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int NOV         = 3,
    parameter int NUV         = 2,
    parameter int OV_TICKS    = 73,
    parameter int UV_TICKS    = 146,
    parameter int DEB_TICKS   = 38000,
    parameter int OFF_TICKS   = 2300,
    parameter int BLANK_TICKS = 75000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_us,
    input  logic [NOV-1:0] ov_flag,
    input  logic [NUV-1:0] uv_flag,
    input  logic           on_req_n,
    output logic           rails_off,
    output logic           pg_ok,
    output logic           fault_latched
);
    localparam int NIN = NOV + NUV + 1;

    logic [NIN-1:0] raw_in, sync_out;
    logic [NOV-1:0] ov_sync, ov_hit;
    logic [NUV-1:0] uv_sync, uv_hit;
    logic           req_sync, deb_req, deb_rise, off_cmd, uv_en;
    latch_state_t   lat_d, lat_q;

    assign raw_in = {on_req_n, uv_flag, ov_flag};

    sg_sync_bank #(
        .W       (NIN),
        .RST_VAL ({REQ_OFF, {(NIN-1){1'b0}}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    assign ov_sync  = sync_out[NOV-1:0];
    assign uv_sync  = sync_out[NOV+NUV-1:NOV];
    assign req_sync = sync_out[NIN-1];

    sg_onoff_ctrl #(
        .DEB_TICKS   (DEB_TICKS),
        .OFF_TICKS   (OFF_TICKS),
        .BLANK_TICKS (BLANK_TICKS)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_us),
        .req_sync (req_sync),
        .deb_req  (deb_req),
        .deb_rise (deb_rise),
        .off_cmd  (off_cmd),
        .uv_en    (uv_en)
    );

    for (genvar i = 0; i < NOV; i++) begin : g_ov
        sg_qual_filter #(.LEN(OV_TICKS)) u_f (
            .clk  (clk),
            .rst  (rst),
            .tick (tick_us),
            .flag (ov_sync[i]),
            .hit  (ov_hit[i])
        );
    end

    for (genvar j = 0; j < NUV; j++) begin : g_uv
        sg_qual_filter #(.LEN(UV_TICKS)) u_f (
            .clk  (clk),
            .rst  (rst),
            .tick (tick_us),
            .flag (uv_sync[j] & uv_en),
            .hit  (uv_hit[j])
        );
    end

    always_comb begin
        lat_d = lat_q;
        if (deb_rise) begin
            lat_d.fault = 1'b0;
        end else if (((|ov_hit) || (|uv_hit)) && (deb_req == REQ_ON)) begin
            lat_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end

    assign rails_off     = lat_q.fault | off_cmd;
    assign pg_ok         = ~lat_q.fault;
    assign fault_latched = lat_q.fault;
endmodule

// File: rtl/supply_guard_checker.sv
module supply_guard_checker #(
    parameter int NOV = 3,
    parameter int NUV = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           deb_req,
    input logic           deb_rise,
    input logic           uv_en,
    input logic [NOV-1:0] ov_sync,
    input logic [NOV-1:0] ov_hit,
    input logic [NUV-1:0] uv_hit,
    input logic           rails_off,
    input logic           fault_latched
);
    // R6: a latched fault keeps the rails off
    a_r6_fault_forces_off: assert property (@(posedge clk) disable iff (rst)
        fault_latched |-> rails_off);

    // R7: the latch only drops on the accepted on-to-off edge
    a_r7_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && !deb_rise) |=> fault_latched);

    // R3: accepted switch-on enables the rails one clock later unless faulted
    a_r3_turn_on_prompt: assert property (@(posedge clk) disable iff (rst)
        $fell(deb_req) |=> ##1 (!rails_off || fault_latched));

    // R5: nothing qualifies on the under-voltage side while blanked
    a_r5_uv_blanked: assert property (@(posedge clk) disable iff (rst)
        (!uv_en && !$past(uv_en)) |-> (uv_hit == '0));

    // R4: an over-voltage qualification follows a synchronised flag
    for (genvar i = 0; i < NOV; i++) begin : g_ov_chk
        a_r4_ov_from_flag: assert property (@(posedge clk) disable iff (rst)
            $rose(ov_hit[i]) |-> $past(ov_sync[i]));
    end
endmodule

bind supply_guard supply_guard_checker #(.NOV(NOV), .NUV(NUV)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .deb_req       (deb_req),
    .deb_rise      (deb_rise),
    .uv_en         (uv_en),
    .ov_sync       (ov_sync),
    .ov_hit        (ov_hit),
    .uv_hit        (uv_hit),
    .rails_off     (rails_off),
    .fault_latched (fault_latched)
);

// File: tb/supply_guard_test.sv
module supply_guard_test;
    localparam int OVQ = 5, UVQ = 10, DEB = 20, OFF = 8, BLK = 30;

    logic       clk = 1'b0, rst = 1'b1, tick_us = 1'b1, on_req_n = 1'b1;
    logic [2:0] ov_flag = '0;
    logic [1:0] uv_flag = '0;
    logic       rails_off, pg_ok, fault_latched;

    int errors = 0, checks = 0, cyc = 0;
    bit slow_tick = 0;

    always #4 clk = ~clk;  // 125 MHz

    supply_guard #(
        .OV_TICKS(OVQ), .UV_TICKS(UVQ), .DEB_TICKS(DEB),
        .OFF_TICKS(OFF), .BLANK_TICKS(BLK)
    ) uut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .ov_flag(ov_flag),
        .uv_flag(uv_flag), .on_req_n(on_req_n), .rails_off(rails_off),
        .pg_ok(pg_ok), .fault_latched(fault_latched)
    );

    // ---------------- behavioural reference model ----------------
    int s1[6], s2[6];            // index 0..2 ov, 3..4 uv, 5 request
    int ovc[3], uvc[2];
    bit ovh[3], uvh[2];
    int m_deb, m_prev, m_off, m_uven, m_fault, dcnt, ocnt, bcnt;

    task automatic model_reset();
        for (int k = 0; k < 6; k++) begin s1[k] = (k == 5); s2[k] = (k == 5); end
        for (int k = 0; k < 3; k++) begin ovc[k] = 0; ovh[k] = 0; end
        for (int k = 0; k < 2; k++) begin uvc[k] = 0; uvh[k] = 0; end
        m_deb = 1; m_prev = 1; m_off = 1; m_uven = 0; m_fault = 0;
        dcnt = 0; ocnt = 0; bcnt = 0;
    endtask

    task automatic model_step();
        int n_deb = m_deb, n_off = m_off, n_uven = m_uven, n_fault = m_fault;
        bit anyhit = 0;
        bit rise = (m_deb == 1) && (m_prev == 0);
        int in_now[6];
        for (int k = 0; k < 3; k++) anyhit |= ovh[k];
        for (int k = 0; k < 2; k++) anyhit |= uvh[k];
        if (rise) n_fault = 0;
        else if (anyhit && m_deb == 0) n_fault = 1;
        // filters see the synchroniser output
        for (int k = 0; k < 3; k++) begin
            if (!s2[k]) begin ovc[k] = 0; ovh[k] = 0; end
            else if (tick_us && !ovh[k]) begin
                if (ovc[k] == OVQ - 1) begin ovh[k] = 1; ovc[k] = 0; end else ovc[k]++;
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (!(s2[3+k] && m_uven)) begin uvc[k] = 0; uvh[k] = 0; end
            else if (tick_us && !uvh[k]) begin
                if (uvc[k] == UVQ - 1) begin uvh[k] = 1; uvc[k] = 0; end else uvc[k]++;
            end
        end
        if (s2[5] == m_deb) dcnt = 0;
        else if (tick_us) begin
            if (dcnt == DEB - 1) begin n_deb = s2[5]; dcnt = 0; end else dcnt++;
        end
        if (m_deb == 0) begin n_off = 0; ocnt = 0; end
        else if (m_off) ocnt = 0;
        else if (tick_us) begin
            if (ocnt == OFF - 1) begin n_off = 1; ocnt = 0; end else ocnt++;
        end
        if (m_deb == 1) begin n_uven = 0; bcnt = 0; end
        else if (!m_uven && tick_us) begin
            if (bcnt == BLK - 1) begin n_uven = 1; bcnt = 0; end else bcnt++;
        end
        m_prev = m_deb; m_deb = n_deb; m_off = n_off; m_uven = n_uven; m_fault = n_fault;
        // R10: two register stages on every input
        in_now = '{ov_flag[0], ov_flag[1], ov_flag[2], uv_flag[0], uv_flag[1], on_req_n};
        for (int k = 0; k < 6; k++) begin s2[k] = s1[k]; s1[k] = in_now[k]; end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) model_reset();
        else     model_step();
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (rails_off !== (m_fault || m_off)) begin
                errors++;
                $display("FAIL R1 cycle %0d rails_off actual=%0b expected=%0b", cyc, rails_off, (m_fault || m_off));
            end
            checks++;
            if (pg_ok !== !m_fault) begin
                errors++;
                $display("FAIL R6 cycle %0d pg_ok actual=%0b expected=%0b", cyc, pg_ok, !m_fault);
            end
            checks++;
            if (fault_latched !== m_fault[0]) begin
                errors++;
                $display("FAIL R7 cycle %0d fault_latched actual=%0b expected=%0b", cyc, fault_latched, m_fault[0]);
            end
        end
    end

    // strobe generator: every cycle, or one in four in the sparse phase
    always @(negedge clk) tick_us <= slow_tick ? ((cyc % 4) == 0) : 1'b1;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        expect_bit("R1", "reset rails_off", rails_off, 1'b1);
        expect_bit("R1", "reset fault", fault_latched, 1'b0);
        expect_bit("R1", "reset pg_ok", pg_ok, 1'b1);

        // R2: short on-pulse rejected
        on_req_n = 1'b0; wait_cyc(10); on_req_n = 1'b1; wait_cyc(40);
        expect_bit("R2", "short request ignored", rails_off, 1'b1);

        // R2/R3: held on-request accepted, rails enabled
        on_req_n = 1'b0; wait_cyc(30);
        expect_bit("R3", "switched on", rails_off, 1'b0);

        // R4: short over-voltage pulse ignored
        ov_flag[1] = 1'b1; wait_cyc(3); ov_flag[1] = 1'b0; wait_cyc(10);
        expect_bit("R4", "short ov ignored", fault_latched, 1'b0);

        // R4/R6: long over-voltage pulse latches
        ov_flag[2] = 1'b1; wait_cyc(12); ov_flag[2] = 1'b0; wait_cyc(5);
        expect_bit("R4", "ov latched", fault_latched, 1'b1);
        expect_bit("R6", "fault forces off", rails_off, 1'b1);
        expect_bit("R6", "fault drops pg", pg_ok, 1'b0);
        wait_cyc(20);
        expect_bit("R7", "latch holds after flag clears", fault_latched, 1'b1);

        // R7: a rejected off-glitch does not clear
        on_req_n = 1'b1; wait_cyc(10); on_req_n = 1'b0; wait_cyc(30);
        expect_bit("R7", "glitch does not clear", fault_latched, 1'b1);

        // R7: accepted off clears
        on_req_n = 1'b1; wait_cyc(40);
        expect_bit("R7", "off edge clears", fault_latched, 1'b0);
        expect_bit("R1", "off state rails_off", rails_off, 1'b1);

        // R8: fault while off is not latched
        ov_flag[0] = 1'b1; wait_cyc(20); ov_flag[0] = 1'b0; wait_cyc(5);
        expect_bit("R8", "no latch while off", fault_latched, 1'b0);

        // R5: under-voltage during blanking ignored, then qualifies
        on_req_n = 1'b0; uv_flag[0] = 1'b1; wait_cyc(45);
        expect_bit("R5", "uv blanked", fault_latched, 1'b0);
        wait_cyc(35);
        expect_bit("R5", "uv latched after blank", fault_latched, 1'b1);
        uv_flag[0] = 1'b0;
        on_req_n = 1'b1; wait_cyc(40);
        on_req_n = 1'b0; wait_cyc(70);
        uv_flag[1] = 1'b1; wait_cyc(6); uv_flag[1] = 1'b0; wait_cyc(10);
        expect_bit("R5", "short uv ignored", fault_latched, 1'b0);

        // R3: switch-off hold-off
        on_req_n = 1'b1; wait_cyc(26);
        expect_bit("R3", "rails held on during hold-off", rails_off, 1'b0);
        wait_cyc(9);
        expect_bit("R3", "rails off after hold-off", rails_off, 1'b1);

        // R9: sparse strobe stretches the windows
        slow_tick = 1; wait_cyc(4);
        on_req_n = 1'b0; wait_cyc(60);
        expect_bit("R9", "debounce counts strobes", rails_off, 1'b1);
        wait_cyc(40);
        expect_bit("R9", "accepted with sparse strobe", rails_off, 1'b0);
        ov_flag[0] = 1'b1; wait_cyc(12); ov_flag[0] = 1'b0; wait_cyc(10);
        expect_bit("R9", "ov filter counts strobes", fault_latched, 1'b0);
        ov_flag[0] = 1'b1; wait_cyc(40); ov_flag[0] = 1'b0; wait_cyc(5);
        expect_bit("R9", "ov qualifies on strobes", fault_latched, 1'b1);

        wait_cyc(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule